// File: doc/BRIEF.md
# Byte-Fed CRC-16 Accelerator

This block computes a 16-bit frame check sequence for a host that hands it data one byte at a time. The host pushes bytes through a stream port: every accepted beat folds the low byte of its 16-bit word into the running checksum within a single clock, so beats may arrive back to back. A 12-bit saturating counter tracks how many bytes have been folded in since the checksum was last cleared.

Control and results sit behind a small 16-bit register window. Setting the top bit of the control word clears the checksum and the byte counter together. That bit clears itself and always reads back as zero. The control word's low twelve bits return the byte count, and a separate result register returns the finished checksum. The checksum uses the CCITT polynomial x^16+x^12+x^5+1 processed least-significant bit first. The running value starts at all ones and the result register presents its bitwise complement. With this setup, the bytes 0xCC, 0xF5, 0xF1, 0xA7 fed after a clear produce 0x51DF.

The data port follows valid/ready rules. A beat is taken on any clock edge where both `din_valid` and `din_ready` are high. The block lowers `din_ready` only in a cycle where a clearing control write is also presented. The host must then hold the beat, and the beat is taken on a later edge. A beat in flight is never dropped or duplicated.

Top module: `crc_accel`

## Requirements
- R1: A register write to address 0 with bit 15 set returns the byte count to 0 and the result register to 0x0000, from the next clock edge onward.
- R2: Reading address 0 returns the byte count in bits 11:0 and zeros in bits 15:12; in particular the clear bit always reads 0.
- R3: An accepted beat feeds only `din_data[7:0]`. Bits 15:8 have no effect on the result register or the count.
- R4: After a clear, accepting 0xCC, 0xF5, 0xF1, 0xA7 in that order leaves a count of 4 and a result register value of 0x51DF.
- R5: The running value starts at 0xFFFF and is updated with the reflected CCITT polynomial (0x8408), one full byte per accepted beat. The result register (address 2) reads its bitwise complement. Back-to-back beats on consecutive clocks are each absorbed.
- R6: The byte count stops at 0xFFF and does not wrap; the checksum keeps updating after the count saturates.
- R7: In a cycle that carries a clearing control write, `din_ready` is low and a presented beat is not absorbed; the clear wins.
- R8: Outside such a cycle `din_ready` is high. With `din_valid` low and no clearing write, neither count nor result changes.
- R9: A control write with bit 15 clear changes nothing. Reads of addresses 1 and 3 return 0x0000.
- R10: After `rst_n` is released the count reads 0 and the result register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data, combinational from `rd_addr` |
| din_valid | input | 1 | Data beat offered |
| din_ready | output | 1 | Data beat can be taken this cycle |
| din_data | input | 16 | Data word; only the low byte is used |

## Verification
The clear request on the register bus and a data beat on the stream port are independent, so both can arrive in the same cycle. The bench provokes this by issuing clearing writes during random stream traffic, often while `din_valid` is high. A directed case holds a beat across the clear so that the beat is absorbed just after it. Each collision is judged by the bench's model: it checks that `din_ready` is low in that cycle, that count and result show a fresh clear, and that the held beat lands exactly once afterwards.

// File: rtl/crcacc_pkg.sv
package crcacc_pkg;

  localparam int ADDR_W = 2;
  localparam int REG_W  = 16;
  localparam int CLR_BIT = 15;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIN  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       clear;
    logic       absorb;
    logic [7:0] byte_v;
  } engine_cmd_t;

endpackage

// File: rtl/crcacc_decode.sv
module crcacc_decode
  import crcacc_pkg::*;
(
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic                din_valid,
  input  logic [REG_W-1:0]    din_data,
  output logic                din_ready,
  output engine_cmd_t         cmd
);

  logic ctrl_hit;

  always_comb begin
    ctrl_hit   = cfg_we && (reg_sel_e'(cfg_addr) == SEL_CTRL);
    cmd.clear  = ctrl_hit && cfg_wdata[CLR_BIT];
    din_ready  = !cmd.clear;
    cmd.absorb = din_valid && din_ready;
    cmd.byte_v = din_data[7:0];
  end

endmodule

// File: rtl/crcacc_engine.sv
module crcacc_engine #(
  parameter int                 CRC_W  = 16,
  parameter int                 BYTE_W = 8,
  parameter logic [CRC_W-1:0]   POLY_R = 16'h8408,
  parameter logic [CRC_W-1:0]   INIT   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              absorb,
  input  logic [BYTE_W-1:0] byte_v,
  output logic [CRC_W-1:0]  crc_state
);

  localparam int PAD_W = CRC_W - BYTE_W;

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] chain [0:BYTE_W];

  assign chain[0] = crc_q ^ {{PAD_W{1'b0}}, byte_v};

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign chain[i+1] = chain[i][0] ? ((chain[i] >> 1) ^ POLY_R)
                                    :  (chain[i] >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= INIT;
    else if (clear)  crc_q <= INIT;
    else if (absorb) crc_q <= chain[BYTE_W];
  end

  assign crc_state = crc_q;

endmodule

// File: rtl/crcacc_counter.sv
module crcacc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clear)                    cnt_q <= '0;
    else if (bump && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crcacc_pkg::*;
#(
  parameter int               CNT_W  = 12,
  parameter int               CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY_R = 16'h8408,
  parameter logic [CRC_W-1:0] INIT   = 16'hFFFF,
  parameter logic [CRC_W-1:0] XOROUT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic [1:0]        rd_addr,
  output logic [15:0]       rd_data,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [15:0]       din_data
);

  localparam int CNT_PAD = REG_W - CNT_W;

  engine_cmd_t      cmd;
  logic [CRC_W-1:0] crc_state;
  logic [CNT_W-1:0] byte_count;

  crcacc_decode u_decode (
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .din_valid (din_valid),
    .din_data  (din_data),
    .din_ready (din_ready),
    .cmd       (cmd)
  );

  crcacc_engine #(
    .CRC_W  (CRC_W),
    .BYTE_W (8),
    .POLY_R (POLY_R),
    .INIT   (INIT)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd.clear),
    .absorb    (cmd.absorb),
    .byte_v    (cmd.byte_v),
    .crc_state (crc_state)
  );

  crcacc_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd.clear),
    .bump  (cmd.absorb),
    .count (byte_count)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      SEL_CTRL: rd_data = {{CNT_PAD{1'b0}}, byte_count};
      SEL_OUT:  rd_data = crc_state ^ XOROUT;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/crc_accel_checker.sv
module crc_accel_checker #(
  parameter int               CNT_W = 12,
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [15:0]      cfg_wdata,
  input logic [1:0]       rd_addr,
  input logic [15:0]      rd_data,
  input logic             din_valid,
  input logic             din_ready,
  input logic [CRC_W-1:0] crc_state,
  input logic [CNT_W-1:0] byte_count
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic clr_wr;
  logic fire;
  assign clr_wr = cfg_we && (cfg_addr == 2'd0) && cfg_wdata[15];
  assign fire   = din_valid && din_ready;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (byte_count == '0) && (crc_state == INIT));

  assert_ctrl_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[15:12] == 4'h0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && byte_count != CNT_TOP) |=> (byte_count == $past(byte_count) + 1'b1));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_count == CNT_TOP && !clr_wr) |=> (byte_count == CNT_TOP));

  assert_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |-> !din_ready);

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!din_valid && !clr_wr) |=> ($stable(byte_count) && $stable(crc_state)));

endmodule

bind crc_accel crc_accel_checker #(
  .CNT_W (CNT_W),
  .CRC_W (CRC_W),
  .INIT  (INIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .din_valid  (din_valid),
  .din_ready  (din_ready),
  .crc_state  (crc_state),
  .byte_count (byte_count)
);

// File: tb/crc_accel_test.sv
`timescale 1ns/100ps
module crc_accel_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        din_valid;
  logic        din_ready;
  logic [15:0] din_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] m_crc;
  logic [11:0] m_cnt;

  always #2.5 clk = ~clk;

  crc_accel uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .din_data  (din_data)
  );

  function automatic logic [15:0] ref_upd(logic [15:0] c, logic [7:0] b);
    c = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #0.4;
    v = rd_data;
  endtask

  task automatic verify(input string req);
    logic [15:0] v;
    peek(2'd0, v);
    chk(v == {4'h0, m_cnt}, req, v, {4'h0, m_cnt});
    peek(2'd2, v);
    chk(v == ~m_crc, req, v, ~m_crc);
  endtask

  task automatic cycle(input logic v, input logic [15:0] d, input logic we,
                       input logic [1:0] wa, input logic [15:0] wd,
                       input bit do_verify, input string req);
    bit clr;
    @(negedge clk);
    din_valid = v; din_data = d; cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    clr = we && (wa == 2'd0) && wd[15];
    #0.4;
    chk(din_ready == !clr, clr ? "R7" : "R8", {15'h0, din_ready}, {15'h0, !clr});
    @(posedge clk);
    if (clr) begin
      m_crc = 16'hFFFF; m_cnt = 12'h000;
    end else if (v) begin
      m_crc = ref_upd(m_crc, d[7:0]);
      if (m_cnt != 12'hFFF) m_cnt = m_cnt + 12'h001;
    end
    #0.2;
    if (do_verify) verify(req);
  endtask

  task automatic idle();
    @(negedge clk);
    din_valid = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1729));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 16'h0;
    rd_addr = 2'd0; din_valid = 1'b0; din_data = 16'h0;
    m_crc = 16'hFFFF; m_cnt = 12'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: state after hardware reset
    verify("R10");

    // R4, R3: check vector with junk in upper bits, back to back (R5)
    cycle(1'b1, 16'hAACC, 1'b0, 2'd0, 16'h0, 1'b0, "R4");
    cycle(1'b1, 16'h55F5, 1'b0, 2'd0, 16'h0, 1'b0, "R4");
    cycle(1'b1, 16'hFFF1, 1'b0, 2'd0, 16'h0, 1'b0, "R4");
    cycle(1'b1, 16'h12A7, 1'b0, 2'd0, 16'h0, 1'b1, "R5");
    peek(2'd2, v);
    chk(v == 16'h51DF, "R4", v, 16'h51DF);
    peek(2'd0, v);
    chk(v == 16'h0004, "R4", v, 16'h0004);

    // R9: non-clearing control write; unused read addresses
    cycle(1'b0, 16'h0, 1'b1, 2'd0, 16'h7FFF, 1'b1, "R9");
    peek(2'd1, v);
    chk(v == 16'h0000, "R9", v, 16'h0000);
    peek(2'd3, v);
    chk(v == 16'h0000, "R9", v, 16'h0000);

    // R1: clear, bit 15 reads 0 afterwards (R2)
    cycle(1'b0, 16'h0, 1'b1, 2'd0, 16'h8000, 1'b1, "R1");
    peek(2'd0, v);
    chk(v[15] == 1'b0, "R2", v, 16'h0000);

    // R3: same low byte, different upper bits, same result
    cycle(1'b1, 16'hFF3C, 1'b0, 2'd0, 16'h0, 1'b1, "R3");
    cycle(1'b0, 16'h0, 1'b1, 2'd0, 16'h8001, 1'b1, "R1");
    cycle(1'b1, 16'h003C, 1'b0, 2'd0, 16'h0, 1'b1, "R3");

    // R7: beat held across a clear is absorbed once after it
    cycle(1'b1, 16'h0077, 1'b1, 2'd0, 16'h8000, 1'b1, "R7");
    cycle(1'b1, 16'h0077, 1'b0, 2'd0, 16'h0, 1'b1, "R7");
    peek(2'd0, v);
    chk(v == 16'h0001, "R7", v, 16'h0001);

    // Random traffic with clear collisions (R5, R7, R8)
    for (int i = 0; i < 3000; i++) begin
      logic vv, we;
      logic [1:0] wa;
      logic [15:0] wd;
      vv = ($urandom % 4) != 0;
      we = ($urandom % 16) == 0;
      wa = 2'($urandom % 4);
      wd = 16'($urandom);
      if (we && ($urandom % 2) == 0) begin wa = 2'd0; wd[15] = 1'b1; end
      cycle(vv, 16'($urandom), we, wa, wd, 1'b1, vv ? "R5" : "R8");
    end

    // R6: saturation of the count
    cycle(1'b0, 16'h0, 1'b1, 2'd0, 16'h8000, 1'b1, "R1");
    for (int i = 0; i < 4100; i++)
      cycle(1'b1, 16'($urandom), 1'b0, 2'd0, 16'h0, (i > 4090), "R6");
    peek(2'd0, v);
    chk(v == 16'h0FFF, "R6", v, 16'h0FFF);
    idle();
    cycle(1'b0, 16'h0, 1'b1, 2'd0, 16'h8000, 1'b1, "R1");
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule